// File: doc/BRIEF.md
# Real-Mode Physical Address Generator with Bit-20 Gate

This block turns a legacy segmented address, a 16-bit segment value and a 16-bit offset, into a physical address. The segment is multiplied by sixteen and the offset is added to it. The carry out of the 20-bit range is kept, so the result is 21 bits wide. With that bit kept, the window of almost 64 KB just above 1 MB (100000 to 10FFEF hex) can be reached. With the bit open, the reachable space is about 1.06 MB.

Two run-time controls limit the top bit:
- An external gate input clears address bit 20 when it is low, so addresses wrap at 1 MB.
- A compatibility-mode input truncates every result to 20 bits, whatever the gate says.

A side flag reports, for each accepted request, whether the unmasked sum went past FFFFF hex. A bench or a monitor can use it to see accesses to the high area even when the gate hid them.

Requests are accepted on a valid strobe. The result appears in registers one clock later. The gate and mode inputs are sampled together with the address inputs.

Top module: `rma_addr_gen`

## Requirements
- R1: While rst_n is low, out_valid, phys_addr and above_1m are all zero.
- R2: With hi_gate_en=1 and compat_mode=0, an accepted request gives phys_addr = seg_in*16 + off_in as a full 21-bit sum, with bit 20 holding the carry.
- R3: The largest result is 10FFEF hex, from segment FFFF and offset FFFF. Segment FFFF with offset 0010 gives exactly 100000 hex.
- R4: With hi_gate_en=0, bit 20 of phys_addr is 0. Bits 19:0 are equal to the low 20 bits of the sum, so addresses wrap around at 1 MB.
- R5: With compat_mode=1, phys_addr is the sum truncated to 20 bits, whatever the value of hi_gate_en.
- R6: above_1m is 1 exactly when the unmasked sum is greater than FFFFF hex, whatever the values of hi_gate_en and compat_mode. A sum of exactly FFFFF hex gives 0.
- R7: out_valid is 1 in the cycle after an edge where in_valid was 1, and 0 in the cycle after an edge where it was 0.
- R8: At an edge with in_valid=0, phys_addr and above_1m keep their values.
- R9: hi_gate_en and compat_mode take effect only on requests accepted at the same edge. Changing them while no request is strobed leaves the held result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is applied asynchronously and released in step with clk. |
| in_valid | input | 1 | Request strobe; the inputs are captured at the edge where this is 1 |
| seg_in | input | 16 | Segment value |
| off_in | input | 16 | Offset value |
| hi_gate_en | input | 1 | 1 lets address bit 20 through; 0 forces it to 0 |
| compat_mode | input | 1 | 1 gives strict 20-bit wraparound |
| out_valid | output | 1 | Registered result valid |
| phys_addr | output | 21 | Registered physical address |
| above_1m | output | 1 | The unmasked sum of the request exceeded FFFFF hex |

## Verification
The bench goes after the carry boundary from several sides:
- A sum of exactly FFFFF hex must not raise above_1m. A design that tests the wrong bit or uses >= would flag it.
- FFFF:0010 must produce exactly 100000 hex, and FFFF:FFFF must produce 10FFEF. A truncating adder would return 00000 and 0FFEF.

Masking is checked with the gate closed, and again with compat_mode set and the gate open. A design that gives the wrong input priority, or masks the flag as well as the address, fails those checks. The gate is also toggled between strobes. A design that applies the gate after the register would change the held address when it should not.

// File: rtl/rma_pkg.sv
package rma_pkg;
  // Default geometry of the legacy segmented model
  localparam int unsigned SEG_W_DEF   = 16;
  localparam int unsigned OFF_W_DEF   = 16;
  localparam int unsigned SHIFT_DEF   = 4;

  // Width that holds the sum including its carry
  function automatic int unsigned sum_width(input int unsigned seg_w,
                                            input int unsigned off_w,
                                            input int unsigned shift);
    int unsigned base_w;
    base_w = seg_w + shift;
    return ((base_w > off_w) ? base_w : off_w) + 1;
  endfunction
endpackage

// File: rtl/rma_sum.sv
module rma_sum #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned LEG_W  = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] sum,
  output logic              over
);
  logic [ADDR_W-1:0] seg_scaled;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    seg_scaled = ADDR_W'(seg) << SHIFT;
    off_ext    = ADDR_W'(off);
    sum        = seg_scaled + off_ext;
    over       = |sum[ADDR_W-1:LEG_W];
  end
endmodule

// File: rtl/rma_gate.sv
module rma_gate #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned LEG_W  = 20
) (
  input  logic [ADDR_W-1:0] raw,
  input  logic              gate_en,
  input  logic              compat,
  output logic [ADDR_W-1:0] masked
);
  logic keep_hi;

  assign keep_hi = gate_en & ~compat;
  assign masked[LEG_W-1:0] = raw[LEG_W-1:0];

  // One AND per bit above the legacy range
  for (genvar b = LEG_W; b < ADDR_W; b++) begin : g_hi_mask
    assign masked[b] = raw[b] & keep_hi;
  end
endmodule

// File: rtl/rma_outreg.sv
module rma_outreg #(
  parameter int unsigned ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              over_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic              over_q,
  output logic              vld_q
);
  logic [ADDR_W-1:0] addr_nxt;
  logic              over_nxt;

  // Next-state: capture only when a request is strobed
  always_comb begin
    addr_nxt = addr_q;
    over_nxt = over_q;
    if (load) begin
      addr_nxt = addr_d;
      over_nxt = over_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      over_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      over_q <= over_nxt;
      vld_q  <= load;
    end
  end
endmodule

// File: rtl/rma_addr_gen.sv
module rma_addr_gen #(
  parameter int unsigned SEG_W = rma_pkg::SEG_W_DEF,
  parameter int unsigned OFF_W = rma_pkg::OFF_W_DEF,
  parameter int unsigned SHIFT = rma_pkg::SHIFT_DEF,
  localparam int unsigned LEG_W  = SEG_W + SHIFT,
  localparam int unsigned ADDR_W = rma_pkg::sum_width(SEG_W, OFF_W, SHIFT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic              hi_gate_en,
  input  logic              compat_mode,
  output logic              out_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              above_1m
);
  logic [ADDR_W-1:0] raw_sum;
  logic [ADDR_W-1:0] gated_sum;
  logic              raw_over;

  rma_sum #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT),
    .ADDR_W(ADDR_W), .LEG_W(LEG_W)
  ) u_sum (
    .seg  (seg_in),
    .off  (off_in),
    .sum  (raw_sum),
    .over (raw_over)
  );

  rma_gate #(.ADDR_W(ADDR_W), .LEG_W(LEG_W)) u_gate (
    .raw     (raw_sum),
    .gate_en (hi_gate_en),
    .compat  (compat_mode),
    .masked  (gated_sum)
  );

  rma_outreg #(.ADDR_W(ADDR_W)) u_oreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid),
    .addr_d (gated_sum),
    .over_d (raw_over),
    .addr_q (phys_addr),
    .over_q (above_1m),
    .vld_q  (out_valid)
  );
endmodule

// File: rtl/rma_addr_gen_chk.sv
module rma_addr_gen_chk #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SEG_W-1:0]  seg_in,
  input logic [OFF_W-1:0]  off_in,
  input logic              hi_gate_en,
  input logic              compat_mode,
  input logic              out_valid,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              above_1m
);
  localparam int unsigned LEG_W = SEG_W + SHIFT;

  logic [ADDR_W-1:0] ref_sum;
  assign ref_sum = (ADDR_W'(seg_in) << SHIFT) + ADDR_W'(off_in);

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hi_gate_en) |=> (phys_addr[ADDR_W-1:LEG_W] == '0));
  // R5
  compat_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && compat_mode) |=> (phys_addr[ADDR_W-1:LEG_W] == '0));
  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phys_addr[LEG_W-1:0] == $past(ref_sum[LEG_W-1:0])));
  // R6
  over_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (above_1m == $past(|ref_sum[ADDR_W-1:LEG_W])));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phys_addr) && $stable(above_1m)));
endmodule

bind rma_addr_gen rma_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_rma_addr_gen.sv
module test_rma_addr_gen;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] seg_in;
  logic [15:0] off_in;
  logic        hi_gate_en;
  logic        compat_mode;
  logic        out_valid;
  logic [20:0] phys_addr;
  logic        above_1m;

  int checks;
  int failures;
  bit done;

  rma_addr_gen i_rma_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_in(seg_in),
    .off_in(off_in), .hi_gate_en(hi_gate_en), .compat_mode(compat_mode),
    .out_valid(out_valid), .phys_addr(phys_addr), .above_1m(above_1m)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [20:0] model_sum(input logic [15:0] s, input logic [15:0] o);
    return {1'b0, s, 4'h0} + {5'h0, o};
  endfunction

  // Strobe one request and check the registered result one edge later
  task automatic issue(input string req, input logic [15:0] s, input logic [15:0] o,
                       input logic g, input logic c);
    logic [20:0] sum;
    logic [20:0] exp_addr;
    sum      = model_sum(s, o);
    exp_addr = (g && !c) ? sum : {1'b0, sum[19:0]};
    @(negedge clk);
    in_valid = 1'b1; seg_in = s; off_in = o; hi_gate_en = g; compat_mode = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "addr",  32'(phys_addr), 32'(exp_addr));
    check("R6", "above", 32'(above_1m), 32'(sum > 21'hFFFFF));
    check("R7", "valid", 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; seg_in = '0; off_in = '0;
    hi_gate_en = 1'b1; compat_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "valid", 32'(out_valid), 32'd0);
    check("R1", "addr",  32'(phys_addr), 32'd0);
    check("R1", "above", 32'(above_1m), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_open_gate;
    issue("R2", 16'h0000, 16'h0000, 1'b1, 1'b0);
    issue("R2", 16'h1234, 16'h5678, 1'b1, 1'b0);
    issue("R2", 16'hF000, 16'hFFF0, 1'b1, 1'b0);
    issue("R2", 16'hA5A5, 16'hC3C3, 1'b1, 1'b0);
  endtask

  task automatic t_extremes;
    issue("R3", 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    check("R3", "max", 32'(phys_addr), 32'h10FFEF);
    issue("R3", 16'hFFFF, 16'h0010, 1'b1, 1'b0);
    check("R3", "1MB", 32'(phys_addr), 32'h100000);
    issue("R6", 16'hF000, 16'hFFFF, 1'b1, 1'b0);
    check("R6", "edge_flag", 32'(above_1m), 32'd0);
  endtask

  task automatic t_gate_closed;
    issue("R4", 16'hFFFF, 16'h0010, 1'b0, 1'b0);
    check("R4", "wrap", 32'(phys_addr), 32'h000000);
    check("R6", "flag_masked", 32'(above_1m), 32'd1);
    issue("R4", 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    issue("R4", 16'h1000, 16'h0100, 1'b0, 1'b0);
  endtask

  task automatic t_compat;
    issue("R5", 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    check("R5", "trunc", 32'(phys_addr), 32'h00FFEF);
    issue("R5", 16'hFFFF, 16'h0020, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    issue("R8", 16'hFFFF, 16'h0100, 1'b1, 1'b0);
    @(negedge clk);
    seg_in = 16'h0001; off_in = 16'h0001;
    @(negedge clk);
    check("R7", "valid_low", 32'(out_valid), 32'd0);
    check("R8", "addr_held", 32'(phys_addr), 32'h1000F0);
    check("R8", "above_held", 32'(above_1m), 32'd1);
  endtask

  task automatic t_gate_late;
    issue("R9", 16'hFFFF, 16'h0200, 1'b1, 1'b0);
    hi_gate_en = 1'b0; compat_mode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9", "after_toggle", 32'(phys_addr), 32'h1001F0);
    hi_gate_en = 1'b1; compat_mode = 1'b0;
    issue("R9", 16'hFFFF, 16'h0200, 1'b0, 1'b0);
    check("R9", "new_gate", 32'(phys_addr), 32'h0001F0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_open_gate();
    t_extremes();
    t_gate_closed();
    t_compat();
    t_hold();
    t_gate_late();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule